// File: doc/BRIEF.md
# Bit-Operable General-Purpose I/O Port

This block is an eight-pin general-purpose I/O port with a built-in single-bit sequencer. Each pin has a direction bit and a data bit. A direction bit of 1 turns the pin into an output that drives its data bit. A direction bit of 0 makes the pin an input. An input pin whose data bit is 1 also has its pull-up switched on. The direction register can only be written. Any read of it returns all ones.

The sequencer sets or clears one bit of either register. It does this as a literal read-modify-write on the register bus: it reads the whole byte, changes the chosen bit and writes the whole byte back. Because of this, a bit operation on the direction register writes back ones for every other bit, since the register reads as all ones. A bit operation on the data register copies the sampled levels of the input pins into their data bits. Both side effects are part of the intended behaviour.

Top module: `gpio_bitop_port`

## Requirements
- R1: After reset both registers are 8'h00, so every pin is an input (pin_oe = 0), pin_out = 0, pin_pu = 0 and busy = 0.
- R2: pin_oe[i] equals direction bit i (1 = output), and pin_out[i] equals data bit i.
- R3: Register address 0 selects the direction register and address 1 selects the data register. While bus_rd is high with address 0, bus_rdata is 8'hFF whatever the stored contents.
- R4: While bus_rd is high with address 1, bit i of bus_rdata is data bit i for an output pin. For an input pin it is the pin level sampled on the previous clock edge.
- R5: pin_pu[i] is 1 exactly when direction bit i is 0 and data bit i is 1.
- R6: A host write with bus_wr high while busy is 0 updates the addressed register at that clock edge. A host write while busy is 1 has no effect.
- R7: A command (cmd_set: 1 = set, 0 = clear; cmd_bit: bit index 0 to 7; cmd_sel: 0 = direction, 1 = data) is accepted on a clock edge with cmd_valid high and busy low. busy then reads 1 for exactly three cycles. The new register value is visible in the first cycle where busy is 0 again.
- R8: A bit operation writes back the byte read from the target register with only the selected bit changed. For example, clearing bit 0 of a stored direction value of 8'h3F reads 8'hFF, writes 8'hFE and turns pins 7 and 6 into outputs.
- R9: A bit operation on the data register loads the sampled input levels into the data bits of the input pins. This can switch their pull-ups on or off.
- R10: A command presented while busy is 1 is dropped and never executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | Register select: 0 direction, 1 data |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data, combinational; 0 when bus_rd is low |
| cmd_valid | input | 1 | Bit-operation command request |
| cmd_set | input | 1 | 1 = set bit, 0 = clear bit |
| cmd_bit | input | 3 | Bit index of the operation |
| cmd_sel | input | 1 | Target register: 0 direction, 1 data |
| busy | output | 1 | Sequencer running its read, modify and write steps |
| pin_in | input | 8 | Pin input levels |
| pin_out | output | 8 | Pin output levels |
| pin_oe | output | 8 | Pin output enables |
| pin_pu | output | 8 | Pin pull-up enables |

## Verification
A corrupted direction or data register shows up on pin_oe, pin_out and pin_pu in the very next cycle, because these outputs decode the stored bits with no extra register. A fault in the sequencer can have several forms: a wrong byte held between steps, the wrong bit index, or a wrong source used for the read. Any of these appears on the pins in the first cycle after busy falls, three cycles after the command is accepted. A hold-off that fails, letting a host write or a second command through while busy is high, changes the pins at most one cycle later.

// File: rtl/gpio_bitop_port.sv
module gpio_bitop_port #(
  parameter int WIDTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_addr,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [WIDTH-1:0]           bus_wdata,
  output logic [WIDTH-1:0]           bus_rdata,
  input  logic                       cmd_valid,
  input  logic                       cmd_set,
  input  logic [$clog2(WIDTH)-1:0]   cmd_bit,
  input  logic                       cmd_sel,
  output logic                       busy,
  input  logic [WIDTH-1:0]           pin_in,
  output logic [WIDTH-1:0]           pin_out,
  output logic [WIDTH-1:0]           pin_oe,
  output logic [WIDTH-1:0]           pin_pu
);
  localparam int IW = $clog2(WIDTH);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_MOD, S_WRITE} seq_t;

  seq_t             st;
  logic [WIDTH-1:0] dir_q, dat_q, pin_q, hold_q;
  logic             op_q, sel_q;
  logic [IW-1:0]    idx_q;

  function automatic logic [WIDTH-1:0] reg_view(input logic sel);
    return sel ? ((dat_q & dir_q) | (pin_q & ~dir_q)) : {WIDTH{1'b1}};
  endfunction

  assign busy      = (st != S_IDLE);
  assign bus_rdata = bus_rd ? reg_view(bus_addr) : '0;
  assign pin_oe    = dir_q;
  assign pin_out   = dat_q;
  assign pin_pu    = ~dir_q & dat_q;

  wire accept  = cmd_valid && !busy;
  wire host_wr = bus_wr && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      dir_q  <= '0;
      dat_q  <= '0;
      pin_q  <= '0;
      hold_q <= '0;
      op_q   <= 1'b0;
      sel_q  <= 1'b0;
      idx_q  <= '0;
    end else begin
      pin_q <= pin_in;
      if (host_wr) begin
        if (bus_addr) dat_q <= bus_wdata;
        else          dir_q <= bus_wdata;
      end
      case (st)
        S_IDLE: if (accept) begin
          op_q  <= cmd_set;
          sel_q <= cmd_sel;
          idx_q <= cmd_bit;
          st    <= S_READ;
        end
        S_READ: begin
          hold_q <= reg_view(sel_q);
          st     <= S_MOD;
        end
        S_MOD: begin
          hold_q[idx_q] <= op_q;
          st            <= S_WRITE;
        end
        default: begin
          if (sel_q) dat_q <= hold_q;
          else       dir_q <= hold_q;
          st <= S_IDLE;
        end
      endcase
    end
  end

  assert_dir_reads_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_addr) |-> (bus_rdata == {WIDTH{1'b1}}));

  assert_pullup_only_inputs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu & pin_oe) == '0);

  assert_busy_three_cycles_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy ##1 busy ##1 !busy);

  assert_regs_frozen_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st != S_WRITE) |=> ($stable(pin_oe) && $stable(pin_out)));

  assert_single_bit_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MOD) |=> ($countones(hold_q ^ $past(hold_q)) <= 1));

  assert_write_back_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WRITE && !sel_q) |=> (pin_oe == $past(hold_q)));

  assert_no_retrigger_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_READ) |=> (st == S_MOD));
endmodule

// File: tb/sim_gpio_bitop_port.sv
`timescale 1ns/1ps
module sim_gpio_bitop_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cmd_valid = 1'b0, cmd_set = 1'b0, cmd_sel = 1'b0;
  logic [2:0] cmd_bit = '0;
  logic       busy;
  logic [7:0] pin_in = '0, pin_out, pin_oe, pin_pu;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gpio_bitop_port #(.WIDTH(8)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_valid(cmd_valid), .cmd_set(cmd_set),
    .cmd_bit(cmd_bit), .cmd_sel(cmd_sel), .busy(busy), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_pu(pin_pu));

  // {dir, data, pins, expected data-register read, expected pull-ups}
  localparam logic [39:0] VEC [5] = '{
    {8'hFF, 8'hA5, 8'h00, 8'hA5, 8'h00},
    {8'h00, 8'hFF, 8'h3C, 8'h3C, 8'hFF},
    {8'h0F, 8'hF0, 8'h5A, 8'h50, 8'hF0},
    {8'h3F, 8'h80, 8'h40, 8'h40, 8'h80},
    {8'hAA, 8'hCC, 8'h0F, 8'h8D, 8'h44}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic addr, input logic [7:0] val);
    @(negedge clk);
    bus_addr = addr; bus_wdata = val; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic host_read(input logic addr, output logic [7:0] val);
    @(negedge clk);
    bus_addr = addr; bus_rd = 1'b1;
    #1 val = bus_rdata;
    bus_rd = 1'b0;
  endtask

  // Drives a command across one edge; returns at the negedge after acceptance.
  task automatic issue(input logic set, input logic [2:0] idx, input logic sel);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_set = set; cmd_bit = idx; cmd_sel = sel;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic setup(input logic [7:0] d, input logic [7:0] v, input logic [7:0] p);
    host_write(1'b0, d);
    host_write(1'b1, v);
    pin_in = p;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    #1;
    chk("R1 oe at reset", pin_oe, 8'h00);
    chk("R1 pu at reset", pin_pu, 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 out after reset", pin_out, 8'h00);
    chk("R1 busy after reset", {7'd0, busy}, 8'h00);

    for (int i = 0; i < 5; i++) begin
      setup(VEC[i][39:32], VEC[i][31:24], VEC[i][23:16]);
      chk("R2 oe", pin_oe, VEC[i][39:32]);
      chk("R2 out", pin_out, VEC[i][31:24]);
      chk("R5 pu", pin_pu, VEC[i][7:0]);
      host_read(1'b1, rd);
      chk("R4 data read", rd, VEC[i][15:8]);
      host_read(1'b0, rd);
      chk("R3 dir read", rd, 8'hFF);
    end

    // R8: clear bit 0 of direction 3F -> FE
    setup(8'h3F, 8'h80, 8'h40);
    chk("R5 pu before", pin_pu, 8'h80);
    issue(1'b0, 3'd0, 1'b0);
    chk("R7 busy step1", {7'd0, busy}, 8'h01);
    @(negedge clk);
    chk("R7 busy step2", {7'd0, busy}, 8'h01);
    chk("R6 oe frozen mid-op", pin_oe, 8'h3F);
    @(negedge clk);
    chk("R7 busy step3", {7'd0, busy}, 8'h01);
    @(negedge clk);
    chk("R7 busy done", {7'd0, busy}, 8'h00);
    chk("R8 dir write-back", pin_oe, 8'hFE);
    chk("R8 pu after", pin_pu, 8'h00);

    // R9: set bit 0 of data register with input pin levels copied in
    setup(8'h3F, 8'h80, 8'h40);
    issue(1'b1, 3'd0, 1'b1);
    repeat (3) @(negedge clk);
    chk("R9 data write-back", pin_out, 8'h41);
    chk("R9 pu shifted", pin_pu, 8'h40);

    // R7 boundary index 7 set, index 3 clear on data
    setup(8'hFF, 8'h00, 8'h00);
    issue(1'b1, 3'd7, 1'b1);
    repeat (3) @(negedge clk);
    chk("R7 set bit7", pin_out, 8'h80);
    setup(8'hFF, 8'hFF, 8'h00);
    issue(1'b0, 3'd3, 1'b1);
    repeat (3) @(negedge clk);
    chk("R7 clear bit3", pin_out, 8'hF7);

    // R10 and R6: second command and host write while busy are dropped
    setup(8'h00, 8'h00, 8'h00);
    issue(1'b1, 3'd2, 1'b0);
    cmd_valid = 1'b1; cmd_set = 1'b0; cmd_bit = 3'd5; cmd_sel = 1'b0;
    bus_addr = 1'b1; bus_wdata = 8'h11; bus_wr = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; bus_wr = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 busy cleared", {7'd0, busy}, 8'h00);
    chk("R10 first op only", pin_oe, 8'hFF);
    chk("R6 host write dropped", pin_out, 8'h00);
    repeat (4) @(negedge clk);
    chk("R10 no late run", pin_oe, 8'hFF);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule